// File: doc/BRIEF.md
# Serial Configuration Loader with Dual Frequency Banks

This block receives configuration words for a frequency synthesiser over a three-wire serial link (data, shift clock and a framing enable). All three serial pins are brought into the system clock domain. While the enable is high, each rising edge of the shift clock pushes one data bit into a 24-bit shift register, most significant bit first. When the enable falls, the top 22 bits of the shift register are copied into one holding register. The two bits shifted in last pick which one.

There are four holding registers: two frequency banks, a reference word and a small A-count buffer. The two frequency banks let the loop hop between two settings. One bank stays in control while software rewrites the other. A bank-select pin names the wanted bank. A one-cycle divider boundary pulse copies that bank into an output shadow, so a divider cycle never sees a half-updated configuration. All outputs are plain decoded fields, and the serial link has no back-pressure.

Top module: `hop_cfg_loader`

## Requirements
- R1: After reset, every output is zero.
- R2: While ser_en is high, each rising edge of ser_clk shifts ser_data into the low end of the 24-bit word, so the first bit sent ends up as bit 23.
- R3: Rising edges of ser_clk while ser_en is low leave the shift register untouched.
- R4: A falling edge of ser_en copies word bits [23:2] into exactly one holding register, selected by word bits [1:0]: 00 frequency bank 1, 01 frequency bank 2, 10 A-count buffer, 11 reference word. Bit 1 is the second-last bit sent.
- R5: A frequency payload holds sense in bit 21, gain in bits [20:19], the M count in bits [18:4] and the A count in bits [3:0]. These appear on pd_sense, cp_gain, div_m and div_a.
- R6: A reference payload holds the wide-prescaler flag in bit 15, the phase-detector enables in bits [14:13] and the reference divide in bits [12:0]. Payload bits [21:16] are discarded.
- R7: An A-count payload drives a_buf from payload bits [3:0].
- R8: Shifting a new word leaves every holding register and output unchanged until the ser_en falling edge.
- R9: On a cyc_end pulse, the frequency outputs take the bank chosen by bank_sel (1 = bank 1, 0 = bank 2), and bank_is_f1 reports that choice. Between pulses, the frequency outputs and bank_is_f1 do not change.
- R10: Reloading the bank that is currently active does not change the outputs until the next cyc_end pulse.
- R11: When presc_wide is 0, div_a bit 3 reads 0. The other A-count bits pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_en | input | 1 | Serial frame enable; its falling edge transfers the word |
| ser_data | input | 1 | Serial data, MSB first |
| bank_sel | input | 1 | Wanted frequency bank (1 = bank 1) |
| cyc_end | input | 1 | Divider cycle boundary pulse |
| div_m | output | 15 | Active M count |
| div_a | output | 4 | Active A count, masked by the prescaler mode |
| cp_gain | output | 2 | Active charge-pump gain code |
| pd_sense | output | 1 | Active phase-detector sense |
| ref_div | output | 13 | Reference divide ratio |
| pd_enable | output | 2 | Phase-detector enable bits |
| presc_wide | output | 1 | Wide prescaler ratio flag |
| a_buf | output | 4 | A-count buffer contents |
| bank_is_f1 | output | 1 | Bank now driving the frequency outputs |

## Verification
A serial pin level sampled at one rising system clock edge takes effect two edges later, after two synchroniser stages and one edge-detect stage. A holding register therefore changes on the third rising edge that sees ser_en low. The frequency outputs change on the rising edge that samples cyc_end high.

The bench reproduces these delays with a history of sampled pin levels rather than a copy of the synchroniser. It compares every output on each falling clock edge, half a cycle after the outputs have settled. Directed checks wait several cycles after a frame closes or a boundary pulse before sampling.

// File: rtl/hcl_pkg.sv
package hcl_pkg;
  parameter int WORD_W = 24;
  parameter int ADDR_W = 2;
  parameter int PAY_W  = WORD_W - ADDR_W;
  parameter int M_W    = 15;
  parameter int A_W    = 4;
  parameter int GAIN_W = 2;
  parameter int RDIV_W = 13;
  parameter int PD_W   = 2;

  typedef struct packed {
    logic              sense;
    logic [GAIN_W-1:0] gain;
    logic [M_W-1:0]    m;
    logic [A_W-1:0]    a;
  } freq_t;

  typedef struct packed {
    logic              presc;
    logic [PD_W-1:0]   pd;
    logic [RDIV_W-1:0] rdiv;
  } ref_t;

  localparam int FREQ_BITS = $bits(freq_t);
  localparam int REF_BITS  = $bits(ref_t);

  typedef enum logic [ADDR_W-1:0] {
    DST_F1  = 2'b00,
    DST_F2  = 2'b01,
    DST_A   = 2'b10,
    DST_REF = 2'b11
  } dst_e;
endpackage

// File: rtl/hcl_sync.sv
module hcl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_en,
  input  logic ser_data,
  output logic shift_evt,
  output logic xfer_evt,
  output logic data_s
);
  // bit 2: shift clock, bit 1: enable, bit 0: data
  logic [STAGES-1:0][2:0] chain;
  logic                   clk_prev;
  logic                   en_prev;
  logic [2:0]             tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= {ser_clk, ser_en, ser_data};
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= '0;
      else        chain[g] <= chain[g-1];
    end
  end

  assign tail = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev <= 1'b0;
      en_prev  <= 1'b0;
    end else begin
      clk_prev <= tail[2];
      en_prev  <= tail[1];
    end
  end

  assign shift_evt = tail[2] & ~clk_prev & tail[1];
  assign xfer_evt  = ~tail[1] & en_prev;
  assign data_s    = tail[0];

  p_evt_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_evt && xfer_evt));
endmodule

// File: rtl/hcl_shifter.sv
module hcl_shifter import hcl_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift,
  input  logic              din,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word <= '0;
    else if (shift) word <= {word[WORD_W-2:0], din};
  end

  p_sr_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(word));
  p_sr_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> word[WORD_W-1:1] == $past(word[WORD_W-2:0]));
endmodule

// File: rtl/hcl_banks.sv
module hcl_banks import hcl_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic [WORD_W-1:0] word,
  output freq_t             f1,
  output freq_t             f2,
  output ref_t              rf,
  output logic [A_W-1:0]    abuf
);
  localparam int NDST = 1 << ADDR_W;

  logic [PAY_W-1:0] payload;
  dst_e             dst;
  logic [NDST-1:0]  we;

  assign payload = word[WORD_W-1:ADDR_W];
  assign dst     = dst_e'(word[ADDR_W-1:0]);

  for (genvar g = 0; g < NDST; g++) begin : g_we
    assign we[g] = xfer && (word[ADDR_W-1:0] == g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f1   <= '0;
      f2   <= '0;
      rf   <= '0;
      abuf <= '0;
    end else begin
      if (we[DST_F1])  f1   <= freq_t'(payload[FREQ_BITS-1:0]);
      if (we[DST_F2])  f2   <= freq_t'(payload[FREQ_BITS-1:0]);
      if (we[DST_REF]) rf   <= ref_t'(payload[REF_BITS-1:0]);
      if (we[DST_A])   abuf <= payload[A_W-1:0];
    end
  end

  p_one_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));
  p_f1_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && dst == DST_F1) |=> f1 == $past(payload[FREQ_BITS-1:0]));
  p_f2_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && dst != DST_F2) |=> $stable(f2));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> ($stable(f1) && $stable(f2) && $stable(rf) && $stable(abuf)));
endmodule

// File: rtl/hcl_select.sv
module hcl_select import hcl_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  boundary,
  input  logic  sel_f1,
  input  freq_t f1,
  input  freq_t f2,
  output freq_t act,
  output logic  act_is_f1
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act       <= '0;
      act_is_f1 <= 1'b0;
    end else if (boundary) begin
      act       <= sel_f1 ? f1 : f2;
      act_is_f1 <= sel_f1;
    end
  end

  p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(act) && $stable(act_is_f1)));
  p_pick_f1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && sel_f1) |=> act == $past(f1));
  p_pick_f2_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !sel_f1) |=> act == $past(f2));
endmodule

// File: rtl/hop_cfg_loader.sv
module hop_cfg_loader import hcl_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_en,
  input  logic              ser_data,
  input  logic              bank_sel,
  input  logic              cyc_end,
  output logic [M_W-1:0]    div_m,
  output logic [A_W-1:0]    div_a,
  output logic [GAIN_W-1:0] cp_gain,
  output logic              pd_sense,
  output logic [RDIV_W-1:0] ref_div,
  output logic [PD_W-1:0]   pd_enable,
  output logic              presc_wide,
  output logic [A_W-1:0]    a_buf,
  output logic              bank_is_f1
);
  logic              shift_evt;
  logic              xfer_evt;
  logic              data_s;
  logic [WORD_W-1:0] word;
  freq_t             f1;
  freq_t             f2;
  freq_t             act;
  ref_t              rf;

  hcl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en(ser_en),
    .ser_data(ser_data), .shift_evt(shift_evt), .xfer_evt(xfer_evt),
    .data_s(data_s)
  );

  hcl_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .shift(shift_evt), .din(data_s), .word(word)
  );

  hcl_banks u_banks (
    .clk(clk), .rst_n(rst_n), .xfer(xfer_evt), .word(word),
    .f1(f1), .f2(f2), .rf(rf), .abuf(a_buf)
  );

  hcl_select u_sel (
    .clk(clk), .rst_n(rst_n), .boundary(cyc_end), .sel_f1(bank_sel),
    .f1(f1), .f2(f2), .act(act), .act_is_f1(bank_is_f1)
  );

  // narrow prescaler mode uses one fewer A-count bit
  assign div_a      = rf.presc ? act.a : {1'b0, act.a[A_W-2:0]};
  assign div_m      = act.m;
  assign cp_gain    = act.gain;
  assign pd_sense   = act.sense;
  assign ref_div    = rf.rdiv;
  assign pd_enable  = rf.pd;
  assign presc_wide = rf.presc;
endmodule

// File: tb/tb_hop_cfg_loader.sv
module tb_hop_cfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_en = 1'b0, ser_data = 1'b0;
  logic bank_sel = 1'b0, cyc_end = 1'b0;
  logic [14:0] div_m;
  logic [3:0]  div_a;
  logic [1:0]  cp_gain;
  logic        pd_sense;
  logic [12:0] ref_div;
  logic [1:0]  pd_enable;
  logic        presc_wide;
  logic [3:0]  a_buf;
  logic        bank_is_f1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hop_cfg_loader dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en(ser_en),
    .ser_data(ser_data), .bank_sel(bank_sel), .cyc_end(cyc_end),
    .div_m(div_m), .div_a(div_a), .cp_gain(cp_gain), .pd_sense(pd_sense),
    .ref_div(ref_div), .pd_enable(pd_enable), .presc_wide(presc_wide),
    .a_buf(a_buf), .bank_is_f1(bank_is_f1)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [2:0]  hist[$];   // {clk,en,data} pin samples, newest first
  logic [23:0] m_sr = '0;
  logic [21:0] m_f1 = '0, m_f2 = '0, m_act = '0;
  logic [15:0] m_ref = '0;
  logic [3:0]  m_ab = '0;
  logic        m_isf1 = 1'b0;
  bit          m_ok = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sr = '0; m_f1 = '0; m_f2 = '0; m_act = '0; m_ref = '0; m_ab = '0;
      m_isf1 = 1'b0;
      hist = '{3'b000, 3'b000, 3'b000};
    end else begin
      logic [2:0] cur, prv;
      cur = hist[1];
      prv = hist[2];
      if (cyc_end) begin
        m_act  = bank_sel ? m_f1 : m_f2;
        m_isf1 = bank_sel;
      end
      if (!cur[1] && prv[1]) begin
        case (m_sr[1:0])
          2'b00: m_f1 = m_sr[23:2];
          2'b01: m_f2 = m_sr[23:2];
          2'b10: m_ab = m_sr[5:2];
          default: m_ref = m_sr[17:2];
        endcase
      end
      if (cur[2] && !prv[2] && cur[1]) m_sr = {m_sr[22:0], cur[0]};
      hist.push_front({ser_clk, ser_en, ser_data});
      void'(hist.pop_back());
    end
    m_ok = 1;
  end

  always @(negedge clk) begin
    if (m_ok && !done) begin
      logic [3:0] ea;
      ea = m_ref[15] ? m_act[3:0] : {1'b0, m_act[2:0]};
      chk("R5 div_m",     div_m,      m_act[18:4]);
      chk("R11 div_a",    div_a,      ea);
      chk("R5 cp_gain",   cp_gain,    m_act[20:19]);
      chk("R5 pd_sense",  pd_sense,   m_act[21]);
      chk("R6 ref_div",   ref_div,    m_ref[12:0]);
      chk("R6 pd_enable", pd_enable,  m_ref[14:13]);
      chk("R6 presc",     presc_wide, m_ref[15]);
      chk("R7 a_buf",     a_buf,      m_ab);
      chk("R9 bank",      bank_is_f1, m_isf1);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [23:0] w, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) begin
      @(negedge clk); ser_clk = 1'b0; ser_data = w[i];
      idle(2);
      ser_clk = 1'b1;
      idle(2);
      ser_clk = 1'b0;
    end
  endtask

  task automatic send_word(input logic [23:0] w);
    @(negedge clk); ser_en = 1'b1;
    idle(2);
    shift_bits(w, 23, 0);
    idle(2);
    ser_en = 1'b0;
    idle(6);
  endtask

  task automatic boundary(input logic sel);
    @(negedge clk); bank_sel = sel; cyc_end = 1'b1;
    @(negedge clk); cyc_end = 1'b0;
    idle(1);
  endtask

  function automatic logic [23:0] mkf(input logic s, input logic [1:0] g,
      input logic [14:0] m, input logic [3:0] a, input logic bank2);
    return {s, g, m, a, 1'b0, bank2};
  endfunction

  function automatic logic [23:0] mkr(input logic p, input logic [1:0] pd,
      input logic [12:0] r);
    return {6'b101101, p, pd, r, 2'b11};
  endfunction

  function automatic logic [23:0] mka(input logic [3:0] a);
    return {18'h3FFF0, a, 2'b10};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected below %0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    // R1: reset state
    chk("R1 div_m", div_m, 0);
    chk("R1 ref_div", ref_div, 0);
    chk("R1 a_buf", a_buf, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(3);

    // R6: reference word, upper payload bits discarded
    send_word(mkr(1'b1, 2'b10, 13'h1ABC));
    chk("R6 ref_div load", ref_div, 13'h1ABC);
    chk("R6 pd_enable load", pd_enable, 2'b10);

    // R2/R4: both banks loaded, outputs wait for a boundary (R9)
    send_word(mkf(1'b1, 2'b01, 15'h5A5A, 4'hB, 1'b0));
    send_word(mkf(1'b0, 2'b11, 15'h1234, 4'h6, 1'b1));
    chk("R9 no boundary yet", div_m, 0);
    boundary(1'b1);
    chk("R2 R4 bank1 m", div_m, 15'h5A5A);
    chk("R5 bank1 a", div_a, 4'hB);
    chk("R9 bank flag", bank_is_f1, 1);
    @(negedge clk); bank_sel = 1'b0;
    idle(3);
    chk("R9 select alone holds", div_m, 15'h5A5A);
    boundary(1'b0);
    chk("R9 bank2 m", div_m, 15'h1234);
    chk("R5 bank2 gain", cp_gain, 2'b11);

    // R11: narrow prescaler masks A bit 3
    send_word(mkr(1'b0, 2'b01, 13'h0123));
    boundary(1'b1);
    chk("R11 masked a", div_a, 4'h3);
    send_word(mkr(1'b1, 2'b10, 13'h1ABC));
    chk("R11 unmasked a", div_a, 4'hB);

    // R7: A-count buffer
    send_word(mka(4'h9));
    chk("R7 a_buf", a_buf, 4'h9);

    // R10: reloading the active bank waits for the boundary
    send_word(mkf(1'b0, 2'b00, 15'h0F0F, 4'h2, 1'b0));
    chk("R10 active reload held", div_m, 15'h5A5A);
    boundary(1'b1);
    chk("R10 after boundary", div_m, 15'h0F0F);

    // R8: half a frame shifted, nothing moves
    @(negedge clk); ser_en = 1'b1;
    idle(2);
    shift_bits(mkr(1'b0, 2'b11, 13'h0777), 23, 12);
    idle(4);
    chk("R8 ref mid-frame", ref_div, 13'h1ABC);
    chk("R8 m mid-frame", div_m, 15'h0F0F);
    shift_bits(mkr(1'b0, 2'b11, 13'h0777), 11, 0);
    idle(2);
    ser_en = 1'b0;
    idle(6);
    chk("R8 ref after frame", ref_div, 13'h0777);

    // R3: shift clocks with enable low are ignored
    send_word(mka(4'h5));
    @(negedge clk); ser_data = 1'b1;
    for (int k = 0; k < 10; k++) begin
      ser_clk = 1'b1; idle(2);
      ser_clk = 1'b0; idle(2);
    end
    ser_data = 1'b0;
    @(negedge clk); ser_en = 1'b1;
    idle(3);
    ser_en = 1'b0;
    idle(6);
    chk("R3 a_buf retransfer", a_buf, 4'h5);
    chk("R3 ref untouched", ref_div, 13'h0777);

    idle(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule